// File: doc/BRIEF.md
# SPI Serial RAM Master

This block is a synchronous SPI master that performs single-byte accesses to an external serial RAM. When `start` is high and the block is idle, it takes a copy of the command byte, the 16-bit address and the write byte. It then runs one fixed frame of 32 serial bits: the command, then the address, then a data byte. The interface uses mode 0. SCK idles low, MOSI changes after a falling SCK edge, and MISO is sampled on a rising SCK edge. SCK runs at half the system clock rate.

A frame whose command equals the read opcode (0x03) collects MISO during its final eight bits and returns the byte on `rd_data`, with a one-cycle `rd_valid` pulse. Any other command, such as the write opcode 0x02, sends the write byte in the data phase and leaves `rd_data` unchanged. Every frame ends with a one-cycle `done` pulse. If `start` is still high at that point, the next frame follows after one clock of deselect.

Top module: `spi_ram_master`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low) and right after reset, `cs_n`=1, `sck`=0, `mosi`=0, `done`=0 and `rd_valid`=0.
- R2: A frame has exactly 32 SCK rising edges. SCK is high only while `cs_n` is low, and each high or low half lasts one system clock.
- R3: MOSI carries the command bits 7..0, then the address bits 15..0, then the data bits 7..0, most significant bit first. It stays stable across each SCK rising edge.
- R4: `cs_n` falls one clock before the first SCK rise and rises one clock after the last SCK fall. It is low for 65 clocks per frame.
- R5: In a frame whose command is 0x03, MISO is sampled on the rising edges of bits 24..31, with the first sampled bit as bit 7. The byte appears on `rd_data` in the same cycle as a one-clock `rd_valid` pulse.
- R6: During the data phase of a 0x03 frame, MOSI is held low.
- R7: In a frame whose command is not 0x03, MISO is ignored. `rd_data` keeps its previous value and `rd_valid` stays low.
- R8: `done` is a one-clock pulse in the cycle in which `cs_n` returns high.
- R9: Command, address and write data are captured when the frame starts. Changes to them during the frame have no effect.
- R10: If `start` is high when `done` is high, `cs_n` stays high for exactly one clock and the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a frame; held high, it chains frames |
| cmd | input | 8 | Command byte (0x03 read, 0x02 write) |
| addr | input | 16 | RAM address |
| wdata | input | 8 | Byte sent in the data phase of a write |
| miso | input | 1 | Serial data from the RAM |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the RAM |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | One-clock strobe for new `rd_data` |
| done | output | 1 | One-clock end-of-frame strobe |

## Verification
The bench acts as a serial RAM. It drives a junk 1 on MISO outside the data phase, so a capture window shifted by one bit returns a corrupted byte. It runs a write straight after a read to catch a design that updates or strobes `rd_data` on writes. It also changes the inputs in the middle of a frame, which exposes a design that shifts live inputs instead of a captured copy. Two further tests cover a chained frame, where a missing or doubled deselect clock shows up as the wrong `cs_n` gap, and an asynchronous reset during a frame, which must return all outputs to idle.

// File: rtl/spi_ram_pkg.sv
package spi_ram_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } seq_state_t;

  // total serial bits in one access
  function automatic int frame_bits(input int cmd_w, input int addr_w, input int data_w);
    return cmd_w + addr_w + data_w;
  endfunction

  // first bit index belonging to the data byte
  function automatic int data_start(input int frame_w, input int data_w);
    return frame_w - data_w;
  endfunction
endpackage

// File: rtl/spi_ram_seq.sv
module spi_ram_seq #(
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic cs_n,
  output logic sck,
  output logic ev_load,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_end,
  output logic data_phase
);
  import spi_ram_pkg::*;

  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] DATA_LO  = CNT_W'(data_start(FRAME_W, DATA_W));

  seq_state_t       state_q;
  logic             sck_q;
  logic             cs_n_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_fall;

  assign ev_load    = (state_q == ST_IDLE) && start;
  assign ev_rise    = (state_q == ST_SHIFT) && !sck_q;
  assign ev_fall    = (state_q == ST_SHIFT) && sck_q;
  assign last_fall  = ev_fall && (cnt_q == LAST_BIT);
  assign ev_end     = (state_q == ST_TAIL);
  assign data_phase = (state_q == ST_SHIFT) && (cnt_q >= DATA_LO);
  assign cs_n       = cs_n_q;
  assign sck        = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SHIFT;
            cs_n_q  <= 1'b0;
            cnt_q   <= '0;
            sck_q   <= 1'b0;
          end
        end
        ST_SHIFT: begin
          sck_q <= ~sck_q;
          if (sck_q) cnt_q <= cnt_q + 1'b1;
          if (last_fall) state_q <= ST_TAIL;
        end
        ST_TAIL: begin
          cs_n_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_ram_txsr.sv
module spi_ram_txsr #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift,
  output logic               mosi
);
  logic [FRAME_W-1:0] sr_q;

  assign mosi = sr_q[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_word;
    else if (shift) sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
  end
endmodule

// File: rtl/spi_ram_rx.sv
module spi_ram_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              miso,
  input  logic              commit,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] col_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (sample) col_q <= {col_q[DATA_W-2:0], miso};
      if (commit) data_q <= col_q;
      valid_q <= commit;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/spi_ram_master.sv
module spi_ram_master #(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              miso,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done
);
  import spi_ram_pkg::*;

  localparam int FRAME_W = frame_bits(CMD_W, ADDR_W, DATA_W);

  // named internal events, also used by the bound checker
  logic ev_load, ev_rise, ev_fall, ev_end, data_phase;
  logic rd_frame_q;
  logic done_q;
  logic is_read_cmd;
  logic [FRAME_W-1:0] load_word;

  assign is_read_cmd = (cmd == CMD_W'(OP_READ));
  assign load_word   = {cmd, addr, is_read_cmd ? {DATA_W{1'b0}} : wdata};

  spi_ram_seq #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cs_n(cs_n), .sck(sck),
    .ev_load(ev_load), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_end(ev_end), .data_phase(data_phase)
  );

  spi_ram_txsr #(.FRAME_W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(ev_load), .load_word(load_word),
    .shift(ev_fall), .mosi(mosi)
  );

  spi_ram_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sample(ev_rise && data_phase && rd_frame_q),
    .miso(miso),
    .commit(ev_end && rd_frame_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_frame_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (ev_load) rd_frame_q <= is_read_cmd;
      done_q <= ev_end;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/spi_ram_master_chk.sv
module spi_ram_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic rd_valid,
  input logic done,
  input logic ev_end,
  input logic data_phase,
  input logic rd_frame_q
);
  a_r2_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  a_r2_sck_high_one: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck);
  a_r3_mosi_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
  a_r4_cs_lead_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sck);
  a_r4_cs_lead_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> sck);
  a_r5_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);
  a_r6_read_data_low: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && rd_frame_q) |-> !mosi);
  a_r7_no_valid_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_end && !rd_frame_q) |=> !rd_valid);
  a_r8_done_one: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_cs: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !cs_n);
endmodule

bind spi_ram_master spi_ram_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sck(sck),
  .mosi(mosi), .rd_valid(rd_valid), .done(done), .ev_end(ev_end),
  .data_phase(data_phase), .rd_frame_q(rd_frame_q)
);

// File: tb/sim_spi_ram_master.sv
`timescale 1ns/1ps
module sim_spi_ram_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [15:0] addr = 16'h0000;
  logic [7:0] wdata = 8'h00;
  logic miso = 1'b0;
  logic cs_n, sck, mosi, rd_valid, done;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_ram_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
    .wdata(wdata), .miso(miso), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
  );

  // {cmd, addr, wdata, byte the RAM returns}
  localparam logic [47:0] VEC [6] = '{
    {8'h02, 16'h0000, 8'h5B, 8'hA5},
    {8'h03, 16'h1234, 8'hFF, 8'hC3},
    {8'h03, 16'hFFFF, 8'h00, 8'h80},
    {8'h02, 16'h8001, 8'h81, 8'hFF},
    {8'h03, 16'h00FF, 8'h77, 8'h01},
    {8'h03, 16'hA5A5, 8'h11, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Plays the RAM: records MOSI on SCK rises, feeds MISO for the next rise.
  task automatic run_frame(input logic [7:0] c, input logic [15:0] a, input logic [7:0] w,
                           input logic [7:0] mb, input bit hold, input bit perturb,
                           output logic [31:0] seen, output int rises, output int cs_low,
                           output bit got_done, output bit got_valid, output logic [7:0] got_data);
    logic prev_sck;
    @(negedge clk);
    cmd = c; addr = a; wdata = w; start = 1'b1;
    rises = 0; cs_low = 0; seen = '0; got_done = 0; got_valid = 0; got_data = '0;
    prev_sck = 1'b0;
    for (int k = 0; k < 200 && !got_done; k++) begin
      @(negedge clk);
      if (!cs_n) begin
        cs_low++;
        if (!hold) start = 1'b0;
        if (perturb) begin cmd = 8'h02; addr = ~a; wdata = ~w; end
      end
      if (sck && !prev_sck) begin
        seen = {seen[30:0], mosi};
        rises++;
      end
      prev_sck = sck;
      if (!sck) miso = (rises >= 24 && rises < 32) ? mb[7 - (rises - 24)] : 1'b1;
      if (done) begin
        got_done = 1; got_valid = rd_valid; got_data = rd_data;
      end
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seen;
    int rises, cs_low;
    bit gd, gv;
    logic [7:0] gdata;
    logic [7:0] last_rd;
    last_rd = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0, "R1 idle pins",
        {29'd0, cs_n, sck, mosi}, 32'h4);
    chk(done === 1'b0 && rd_valid === 1'b0 && rd_data === 8'h00, "R1 strobes",
        {22'd0, done, rd_valid, rd_data}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n === 1'b1, "R1 idle after release", {31'd0, cs_n}, 32'h1);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] c, w, mb;
      logic [15:0] a;
      logic [31:0] exp_word;
      bit is_rd;
      {c, a, w, mb} = VEC[i];
      is_rd = (c == 8'h03);
      exp_word = {c, a, is_rd ? 8'h00 : w};
      run_frame(c, a, w, mb, 0, 0, seen, rises, cs_low, gd, gv, gdata);
      chk(seen === exp_word, is_rd ? "R3 R6 mosi frame" : "R3 mosi frame", seen, exp_word);
      chk(rises == 32, "R2 sck rises", rises, 32);
      chk(cs_low == 65, "R4 cs low span", cs_low, 65);
      chk(gd, "R8 done seen", {31'd0, gd}, 32'h1);
      chk(gv == is_rd, "R5 R7 valid strobe", {31'd0, gv}, {31'd0, is_rd});
      if (is_rd) begin
        chk(gdata === mb, "R5 read byte", gdata, mb);
        last_rd = mb;
      end else begin
        chk(gdata === last_rd, "R7 rd_data held", gdata, last_rd);
      end
      @(negedge clk);
      chk(done === 1'b0 && rd_valid === 1'b0, "R8 done one clock",
          {30'd0, done, rd_valid}, 32'h0);
    end

    // R9: inputs changed during the frame
    run_frame(8'h03, 16'h3C5A, 8'h99, 8'h6E, 0, 1, seen, rises, cs_low, gd, gv, gdata);
    chk(seen === 32'h033C5A00, "R9 latched frame", seen, 32'h033C5A00);
    chk(gv && gdata === 8'h6E, "R9 latched read", {23'd0, gv, gdata}, {23'd1, 8'h6E});

    // R10: start held through the end of a frame
    run_frame(8'h02, 16'h0102, 8'h33, 8'h00, 1, 0, seen, rises, cs_low, gd, gv, gdata);
    chk(gd && cs_n === 1'b1, "R10 deselect clock", {31'd0, cs_n}, 32'h1);
    @(negedge clk);
    chk(cs_n === 1'b0, "R10 next frame started", {31'd0, cs_n}, 32'h0);
    start = 1'b0;
    rises = 0;
    begin
      logic prev;
      bit fin;
      prev = sck; fin = 0;
      for (int k = 0; k < 200 && !fin; k++) begin
        @(negedge clk);
        if (sck && !prev) rises++;
        prev = sck;
        if (done) fin = 1;
      end
    end
    chk(rises == 32, "R10 R2 chained frame rises", rises, 32);

    // R1: reset in the middle of a frame
    @(negedge clk);
    cmd = 8'h02; addr = 16'hFFFF; wdata = 8'hFF; start = 1'b1;
    repeat (12) @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0 && done === 1'b0,
        "R1 reset mid frame", {28'd0, cs_n, sck, mosi, done}, 32'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule